// File: doc/BRIEF.md
# Channel Status Double Buffer

This block keeps one complete block of AES3 channel status for the two subframe channels (A and B), 192 bits each, in two cascaded stages. The host stage sits behind a byte-wide register port, and software edits it freely. The transmit stage feeds one status bit per channel to the AES3 serializer each time a frame strobe arrives. The two stages never mix inside a block. On the frame strobe that starts a new block, the entire host stage is copied into the transmit stage, so the transmitter always sends a coherent block.

Software can set an inhibit bit to hold off the copy while it performs a long edit. Each completed copy sets a sticky event flag, which drives the interrupt output when it is enabled. Software uses the flag to time its accesses. When the block being sent carries the professional flag (the first bit of the block), the final status byte is replaced on the wire by a CRC that the block computes from the 184 bits before it.

Top module: `chs_dbuf`

## Requirements
- R1: Channel A bytes 0..23 are at register addresses 0x20..0x37 and channel B bytes 0..23 are at 0x38..0x4F. A write stores the byte. A read pulse loads the addressed byte into `reg_rdata` on the next clock edge, and `reg_rdata` holds that value until the next read.
- R2: Status bit k (0..191) of a channel is bit 7-(k mod 8) of byte k/8. The first bit sent in a block is therefore the MSB of that channel's byte 0.
- R3: Host writes never change the transmitted bits of the block in progress. The transmit stage changes only through a block copy.
- R4: On a frame strobe at bit index 0 with inhibit clear, all 48 host bytes are copied into the transmit stage. The bit sent at index 0 already comes from the newly copied data.
- R5: Each `frame_stb` pulse sends the bit at the current index and then advances the index, which wraps from 191 to 0. `cs_a` and `cs_b` take the new bits on the same clock edge and hold them between strobes. `blk_start` is high for exactly the one cycle after a strobe at index 0.
- R6: Control register 0x10 holds inhibit in bit 0 and interrupt enable in bit 1, and reads back as {6'b0, enable, inhibit}. While inhibit is 1, no copy occurs, the previous transmit contents are sent again, and the event flag is not set.
- R7: Each copy sets the event flag, which is bit 0 of status register 0x11. `irq` equals flag AND enable and updates on the same edge as the flag.
- R8: The flag stays set until the host writes 0x11 with bit 0 = 1. If a copy and a clear occur on the same edge, the flag stays set.
- R9: If bit 0 of a channel's transmitted block is 1 (professional), bits 184..191 of that channel are replaced, MSB first, by CRC-8 with polynomial x^8+x^4+x^3+x^2+1 (0x1D) and seed 0xFF. The CRC is taken over bits 0..183 in the order they are sent.
- R10: If bit 0 of a channel's transmitted block is 0 (consumer), byte 23 is sent exactly as stored.
- R11: Writes to any address outside 0x10, 0x11 and 0x20..0x4F have no effect, and reads of such addresses return 0x00.
- R12: A synchronous reset clears both stages, the control bits, the flag and the bit index, and drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| frame_stb | input | 1 | One pulse per output frame |
| blk_start | output | 1 | Pulse after the strobe at index 0 |
| cs_a | output | 1 | Channel A status bit |
| cs_b | output | 1 | Channel B status bit |
| irq | output | 1 | Copy-event interrupt |

## Verification
The bench drives both a strobe on every clock and a strobe every third clock, so any dependence of the index or output timing on strobe spacing shows up as a miscompare. The data patterns differ between channels and between blocks, and they pair a consumer channel with a professional one, which separates swapped channels, reversed bit order and a CRC applied to the wrong channel. Edits made in the middle of a block, blocks sent under inhibit, and a flag clear landing on the same edge as a copy each distinguish a correct design from one that copies early or continuously, one that ignores inhibit, and one that gives the clear priority over the set.

// File: rtl/chs_pkg.sv
package chs_pkg;
  localparam int CHANNELS = 2;
  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_SEED = 8'hFF;

  // one serial CRC step, input bit in stream order
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic d);
    logic fb;
    fb = c[7] ^ d;
    return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  endfunction
endpackage

// File: rtl/chs_host_regs.sv
module chs_host_regs #(
  parameter int BYTES = 24,
  parameter int AW = 7,
  parameter logic [AW-1:0] BASE_ADDR = 7'h20,
  parameter logic [AW-1:0] CTRL_ADDR = 7'h10,
  parameter logic [AW-1:0] STAT_ADDR = 7'h11
) (
  input  logic clk,
  input  logic rst,
  input  logic reg_wr,
  input  logic reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic copy_ev,
  output logic [1:0][BYTES-1:0][7:0] e_blk,
  output logic inhibit,
  output logic irq_en,
  output logic irq_flag,
  output logic irq,
  output logic [7:0] reg_rdata
);
  localparam int BW = $clog2(BYTES);
  localparam logic [AW-1:0] BYTES_AW = AW'(BYTES);
  localparam logic [AW-1:0] B_BASE = BASE_ADDR + BYTES_AW;

  logic [AW-1:0] off_a, off_b;
  logic hit_a, hit_b, wr_ctrl, clr_flag, flag_d, ien_d;
  logic [BW-1:0] widx;
  logic [7:0] rd_val;

  // wrapped subtraction: addresses below a base become large and miss
  assign off_a = reg_addr - BASE_ADDR;
  assign off_b = reg_addr - B_BASE;
  assign hit_a = off_a < BYTES_AW;
  assign hit_b = off_b < BYTES_AW;
  assign widx  = hit_a ? off_a[BW-1:0] : off_b[BW-1:0];

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [BYTES-1:0][7:0] mem_q;
    logic sel;
    assign sel = (ch == 0) ? hit_a : hit_b;
    always_ff @(posedge clk) begin
      if (rst) mem_q <= '0;
      else if (reg_wr && sel) mem_q[widx] <= reg_wdata;
    end
    assign e_blk[ch] = mem_q;
  end

  assign wr_ctrl  = reg_wr && (reg_addr == CTRL_ADDR);
  assign clr_flag = reg_wr && (reg_addr == STAT_ADDR) && reg_wdata[0];
  assign flag_d   = copy_ev | (irq_flag & ~clr_flag);   // set wins
  assign ien_d    = wr_ctrl ? reg_wdata[1] : irq_en;

  always_comb begin
    rd_val = 8'h00;
    if (hit_a) rd_val = e_blk[0][off_a[BW-1:0]];
    else if (hit_b) rd_val = e_blk[1][off_b[BW-1:0]];
    else if (reg_addr == CTRL_ADDR) rd_val = {6'b0, irq_en, inhibit};
    else if (reg_addr == STAT_ADDR) rd_val = {7'b0, irq_flag};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inhibit   <= 1'b0;
      irq_en    <= 1'b0;
      irq_flag  <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= 8'h00;
    end else begin
      if (wr_ctrl) inhibit <= reg_wdata[0];
      irq_en   <= ien_d;
      irq_flag <= flag_d;
      irq      <= flag_d & ien_d;
      if (reg_rd) reg_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/chs_seq.sv
module chs_seq #(
  parameter int BLK_BITS = 192
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  input  logic inhibit,
  output logic [$clog2(BLK_BITS)-1:0] idx,
  output logic copy_ev,
  output logic blk_start
);
  localparam int IW = $clog2(BLK_BITS);
  localparam logic [IW-1:0] LAST = IW'(BLK_BITS - 1);

  logic at_start;
  assign at_start = (idx == '0);
  assign copy_ev  = frame_stb & at_start & ~inhibit;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      blk_start <= 1'b0;
    end else begin
      blk_start <= frame_stb & at_start;
      if (frame_stb) idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/chs_lane.sv
module chs_lane #(
  parameter int BLK_BITS = 192
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  input  logic copy_ev,
  input  logic [$clog2(BLK_BITS)-1:0] idx,
  input  logic [BLK_BITS/8-1:0][7:0] e_blk,
  output logic cs_bit
);
  import chs_pkg::*;
  localparam int BYTES = BLK_BITS / 8;
  localparam int IW = $clog2(BLK_BITS);
  localparam logic [IW-1:0] CRC_AT = IW'(BLK_BITS - 8);

  logic [BYTES-1:0][7:0] f_q, src;
  logic [7:0] crc_q;
  logic pro_q, raw, in_crc, at_start;

  assign at_start = (idx == '0);
  assign src    = copy_ev ? e_blk : f_q;     // bit 0 comes from the fresh copy
  assign raw    = src[idx[IW-1:3]][~idx[2:0]];
  assign in_crc = idx >= CRC_AT;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q    <= '0;
      crc_q  <= CRC_SEED;
      pro_q  <= 1'b0;
      cs_bit <= 1'b0;
    end else begin
      if (copy_ev) f_q <= e_blk;
      if (frame_stb) begin
        if (at_start) pro_q <= raw;
        if (!in_crc) crc_q <= crc8_step(at_start ? CRC_SEED : crc_q, raw);
        cs_bit <= (in_crc && pro_q) ? crc_q[~idx[2:0]] : raw;
      end
    end
  end
endmodule

// File: rtl/chs_dbuf.sv
module chs_dbuf #(
  parameter int BLK_BITS = 192,
  parameter int AW = 7,
  parameter logic [AW-1:0] BASE_ADDR = 7'h20,
  parameter logic [AW-1:0] CTRL_ADDR = 7'h10,
  parameter logic [AW-1:0] STAT_ADDR = 7'h11
) (
  input  logic clk,
  input  logic rst,
  input  logic reg_wr,
  input  logic reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic frame_stb,
  output logic blk_start,
  output logic cs_a,
  output logic cs_b,
  output logic irq
);
  import chs_pkg::*;
  localparam int BYTES = BLK_BITS / 8;
  localparam int IW = $clog2(BLK_BITS);

  logic [1:0][BYTES-1:0][7:0] e_blk;
  logic [IW-1:0] seq_idx;
  logic copy_ev, inhibit, irq_en, irq_flag;
  logic [CHANNELS-1:0] lane_bit;

  chs_host_regs #(.BYTES(BYTES), .AW(AW), .BASE_ADDR(BASE_ADDR),
                  .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)) u_host (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .copy_ev(copy_ev),
    .e_blk(e_blk), .inhibit(inhibit), .irq_en(irq_en),
    .irq_flag(irq_flag), .irq(irq), .reg_rdata(reg_rdata)
  );

  chs_seq #(.BLK_BITS(BLK_BITS)) u_seq (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .inhibit(inhibit),
    .idx(seq_idx), .copy_ev(copy_ev), .blk_start(blk_start)
  );

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_lane
    chs_lane #(.BLK_BITS(BLK_BITS)) u_lane (
      .clk(clk), .rst(rst), .frame_stb(frame_stb), .copy_ev(copy_ev),
      .idx(seq_idx), .e_blk(e_blk[ch]), .cs_bit(lane_bit[ch])
    );
  end

  assign cs_a = lane_bit[0];
  assign cs_b = lane_bit[1];
endmodule

// File: rtl/chs_checker.sv
module chs_checker #(
  parameter int BLK_BITS = 192,
  parameter int AW = 7,
  parameter logic [AW-1:0] BASE_ADDR = 7'h20,
  parameter logic [AW-1:0] CTRL_ADDR = 7'h10,
  parameter logic [AW-1:0] STAT_ADDR = 7'h11
) (
  input logic clk,
  input logic rst,
  input logic frame_stb,
  input logic blk_start,
  input logic [$clog2(BLK_BITS)-1:0] seq_idx,
  input logic copy_ev,
  input logic irq_flag,
  input logic irq_en,
  input logic irq,
  input logic reg_wr,
  input logic reg_rd,
  input logic [AW-1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata
);
  localparam logic [AW-1:0] SPAN = AW'(2 * (BLK_BITS / 8));
  logic unmapped, clr;
  logic [AW-1:0] off;
  assign off      = reg_addr - BASE_ADDR;
  assign unmapped = !(off < SPAN) && reg_addr != CTRL_ADDR && reg_addr != STAT_ADDR;
  assign clr      = reg_wr && reg_addr == STAT_ADDR && reg_wdata[0];

  assert_blk_start_R5: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && seq_idx == '0) |=> blk_start);
  assert_blk_start_only_R5: assert property (@(posedge clk) disable iff (rst)
    !(frame_stb && seq_idx == '0) |=> !blk_start);
  assert_idx_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(seq_idx));
  assert_idx_range_R5: assert property (@(posedge clk) disable iff (rst)
    32'(seq_idx) < BLK_BITS);
  assert_copy_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
    copy_ev |=> irq_flag);
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (irq_flag && irq_en));
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !clr) |=> irq_flag);
  assert_flag_source_R8: assert property (@(posedge clk) disable iff (rst)
    (!irq_flag && !copy_ev) |=> !irq_flag);
  assert_unmapped_read_R11: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && unmapped) |=> reg_rdata == 8'h00);
endmodule

bind chs_dbuf chs_checker #(.BLK_BITS(BLK_BITS), .AW(AW), .BASE_ADDR(BASE_ADDR),
                            .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)) u_chk (
  .clk(clk), .rst(rst), .frame_stb(frame_stb), .blk_start(blk_start),
  .seq_idx(seq_idx), .copy_ev(copy_ev), .irq_flag(irq_flag), .irq_en(irq_en),
  .irq(irq), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/tb_chs_dbuf.sv
`timescale 1ns/1ps
module tb_chs_dbuf;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0, frame_stb = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic blk_start, cs_a, cs_b, irq;

  always #2.5 clk = ~clk;

  chs_dbuf dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_stb(frame_stb), .blk_start(blk_start), .cs_a(cs_a),
    .cs_b(cs_b), .irq(irq)
  );

  // behavioural reference
  bit [7:0] m_e [2][24];
  bit [7:0] m_f [2][24];
  bit [7:0] m_crc [2];
  bit m_pro [2];
  bit exp_cs [2];
  int m_idx;
  bit m_inh, m_ien, m_flag, exp_bs, exp_irq;
  bit [7:0] exp_rd;
  int vectors = 0, fails = 0;
  bit done = 0;
  string scen = "R12 reset";

  function automatic bit [7:0] crc_of(int ch);
    bit [7:0] c = 8'hFF;
    for (int b = 0; b < 23; b++)
      for (int k = 7; k >= 0; k--) begin
        bit fb = c[7] ^ m_f[ch][b][k];
        c = (c << 1) ^ (fb ? 8'h1D : 8'h00);
      end
    return c;
  endfunction

  function automatic bit [7:0] read_val(int a);
    if (a >= 32 && a < 56) return m_e[0][a-32];
    if (a >= 56 && a < 80) return m_e[1][a-56];
    if (a == 16) return {6'b0, m_ien, m_inh};
    if (a == 17) return {7'b0, m_flag};
    return 8'h00;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      for (int b = 0; b < 24; b++) begin m_e[c][b] = 0; m_f[c][b] = 0; end
      exp_cs[c] = 0; m_pro[c] = 0; m_crc[c] = 8'hFF;
    end
    m_idx = 0; m_inh = 0; m_ien = 0; m_flag = 0; exp_bs = 0; exp_irq = 0; exp_rd = 0;
  endtask

  task automatic model_step(bit wr, bit rd, int a, bit [7:0] wd, bit stb);
    bit copy = stb && m_idx == 0 && !m_inh;
    bit clr = wr && a == 17 && wd[0];
    if (rd) exp_rd = read_val(a);
    if (copy) m_f = m_e;
    if (stb) begin
      if (m_idx == 0)
        for (int c = 0; c < 2; c++) begin m_pro[c] = m_f[c][0][7]; m_crc[c] = crc_of(c); end
      for (int c = 0; c < 2; c++) begin
        bit v = m_f[c][m_idx/8][7 - m_idx%8];
        if (m_idx >= 184 && m_pro[c]) v = m_crc[c][7 - (m_idx-184)];
        exp_cs[c] = v;
      end
      exp_bs = (m_idx == 0);
      m_idx = (m_idx + 1) % 192;
    end else exp_bs = 0;
    if (wr) begin
      if (a >= 32 && a < 56) m_e[0][a-32] = wd;
      else if (a >= 56 && a < 80) m_e[1][a-56] = wd;
      else if (a == 16) begin m_inh = wd[0]; m_ien = wd[1]; end
    end
    m_flag = copy | (m_flag & !clr);
    exp_irq = m_flag & m_ien;
  endtask

  task automatic chk(string what, string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] during %s: actual %0h expected %0h at %0t", what, req, scen, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("cs_a", "R2 R4 R9 R10", int'(cs_a), int'(exp_cs[0]));
    chk("cs_b", "R2 R4 R9 R10", int'(cs_b), int'(exp_cs[1]));
    chk("blk_start", "R5", int'(blk_start), int'(exp_bs));
    chk("irq", "R7 R8", int'(irq), int'(exp_irq));
    chk("reg_rdata", "R1 R11", int'(reg_rdata), int'(exp_rd));
  endtask

  task automatic cyc(bit wr, bit rd, int a, bit [7:0] wd, bit stb);
    reg_wr = wr; reg_rd = rd; reg_addr = 7'(a); reg_wdata = wd; frame_stb = stb;
    model_step(wr, rd, a, wd, stb);
    @(posedge clk); #1;
    compare_all();
  endtask

  task automatic wr_reg(int a, bit [7:0] d); cyc(1, 0, a, d, 0); endtask
  task automatic rd_reg(int a); cyc(0, 1, a, 0, 0); endtask
  task automatic frames(int n, int gap);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 0, 0, 1);
      for (int g = 0; g < gap; g++) cyc(0, 0, 0, 0, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired during %s", scen);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    repeat (3) @(posedge clk);
    #1; model_reset(); compare_all();
    rst = 0;
    rd_reg(16'h20); rd_reg(16'h10); rd_reg(16'h11);

    // R1: fill both channels; A consumer, B professional
    scen = "R1 fill";
    for (int b = 0; b < 24; b++) wr_reg(32 + b, (b == 0) ? 8'h40 : 8'((b * 17 + 3) & 255));
    for (int b = 0; b < 24; b++) wr_reg(56 + b, (b == 0) ? 8'hA5 : 8'((b * 37 + 5) & 255));
    for (int b = 0; b < 48; b += 7) rd_reg(32 + b);
    rd_reg(16'h4F);

    // R11: unmapped writes ignored, reads return zero, neighbours unchanged
    scen = "R11 unmapped";
    wr_reg(16'h1F, 8'hFF); wr_reg(16'h50, 8'hFF); wr_reg(16'h7F, 8'hFF); wr_reg(16'h12, 8'hFF);
    rd_reg(16'h1F); rd_reg(16'h50); rd_reg(16'h7F); rd_reg(16'h12);
    rd_reg(16'h20); rd_reg(16'h4F); rd_reg(16'h10);

    // R4 R5 R7 R9 R10: enable irq, send blocks with dense and sparse strobes
    scen = "R4 R9 R10 dense strobes";
    wr_reg(16'h10, 8'h02); rd_reg(16'h10);
    frames(192, 0);
    scen = "R5 sparse strobes";
    frames(192, 2);
    rd_reg(16'h11);

    // R8: write-one clear
    scen = "R8 clear";
    wr_reg(16'h11, 8'h00); rd_reg(16'h11);
    wr_reg(16'h11, 8'h01); rd_reg(16'h11);

    // R3: edits in mid-block stay out of the block in progress
    scen = "R3 mid-block edit";
    frames(60, 1);
    wr_reg(32 + 3, 8'h5A); wr_reg(56 + 23, 8'h0F); wr_reg(56 + 1, 8'hC3);
    frames(132, 1);
    frames(192, 0);

    // R8: clear coincides with copy, set wins
    scen = "R8 set beats clear";
    wr_reg(16'h11, 8'h01);
    while (m_idx != 0) cyc(0, 0, 0, 0, 1);
    cyc(1, 0, 16'h11, 8'h01, 1);
    rd_reg(16'h11);
    frames(191, 0);

    // R6: inhibit keeps old contents and no event
    scen = "R6 inhibit";
    wr_reg(16'h10, 8'h03); wr_reg(16'h11, 8'h01);
    wr_reg(32, 8'h80); wr_reg(32 + 23, 8'h77); wr_reg(56, 8'h00);
    frames(192, 1);
    frames(192, 0);
    rd_reg(16'h11); rd_reg(16'h10);

    // R9 R10: release inhibit, A now professional, B consumer
    scen = "R9 R10 mode swap";
    wr_reg(16'h10, 8'h02);
    frames(192, 0);
    frames(5, 0);

    // R12: reset again mid-block
    scen = "R12 second reset";
    rst = 1; @(posedge clk); #1; model_reset(); compare_all();
    rst = 0;
    rd_reg(16'h20); rd_reg(16'h11);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule